// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It takes a start event from one of six sources, picked by a 3-bit select: a software start strobe, one of four timer overflow pulses, or an external start pin. It then runs a tracking window and a bit-by-bit conversion. The sampler, comparator and trial DAC sit outside the block. The block drives the sampler's track control and presents a trial code to the DAC. It reads back one comparator bit for each step and publishes the final code together with busy and done flags.

A mode input picks one of two tracking policies:

- **Continuous tracking.** The sampler tracks whenever no conversion runs, and a start event goes straight into conversion.
- **Low-power tracking.** The sampler rests when idle.
  - An internal start opens a fixed tracking window of three SAR clocks before converting.
  - With the external pin selected, the sampler tracks while the pin is low, and conversion begins on the pin's rising edge.

A sleep input forces the sampler off and blocks new starts. All sequencing advances only on cycles where the SAR clock enable is high. Start events are taken on any system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Start source by `trig_sel`: 3'b000 software strobe `sw_start`, 3'b001 `tmr_ovf[0]`, 3'b011 `tmr_ovf[1]`, 3'b010 `tmr_ovf[2]`, 3'b101 `tmr_ovf[3]`, 3'b100 a rising edge of `ext_start`; codes 3'b110 and 3'b111 start nothing, and a source that is not selected has no effect.
- R2: With `mode_lp`=0, `track` is 1 while idle and 0 for every cycle that `busy` is 1; a conversion covers exactly 11 SAR-enabled cycles while busy.
- R3: With `mode_lp`=1 and an internal source, `track` is 0 while idle; after a start, `track` is 1 for exactly 3 SAR-enabled cycles and then 11 conversion cycles follow, 14 SAR-enabled busy cycles in total.
- R4: With `mode_lp`=1 and `trig_sel`=3'b100, idle `track` equals the inverse of the synchronized `ext_start` level; a rising edge, seen through a two-flop synchronizer, starts conversion directly, with 11 SAR-enabled busy cycles and no tracking window.
- R5: The conversion resolves bits MSB first; during each of the first 10 conversion steps `dac_code` shows the kept bits plus the current trial bit; `cmp_in`=1 keeps the trial bit; `result` then equals the largest code not above the analog input, and `result` changes only in the cycle `done` is 1.
- R6: `busy` rises the cycle after an accepted start and falls in the same cycle that `done` pulses high for exactly one system clock.
- R7: A start event of any source while `busy` is 1 is ignored: the running conversion keeps its length and produces exactly one `done`.
- R8: While `sleep` is 1, `track` is 0 and no conversion starts.
- R9: On cycles with `sar_ce`=0 the sequence does not advance: `busy` stays high and no `done` appears.
- R10: After reset the block is idle: `busy`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sar_ce | input | 1 | SAR clock enable; one sequencing step per high cycle |
| mode_lp | input | 1 | 0 continuous tracking, 1 low-power tracking |
| trig_sel | input | 3 | Start source select |
| sw_start | input | 1 | Software start strobe |
| tmr_ovf | input | 4 | Timer overflow pulses, bit index is the timer number |
| ext_start | input | 1 | Asynchronous external start pin |
| sleep | input | 1 | Standby: sampler off, no new starts |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| track | output | 1 | Sampler control, 1 = track, 0 = hold / off |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last completed conversion code |
| dac_code | output | 10 | Trial code for the external DAC |

## Verification
The conversion path is swept over every one of the 1024 input codes with software starts in continuous mode. This separates a wrong trial-bit order or keep/clear decision from a correct binary search. Sparser code sweeps in low-power mode with internal and external starts, at slower SAR-enable ratios, show whether the window length is counted in SAR-enabled cycles (3+11 versus 11) rather than in system clocks. Every select code is paired with every source, which tells a correct source map apart from swapped timers or a leaking unselected input. Starts repeated while busy, a held-low enable and a sleep period show that these are rejected rather than restarting or advancing the sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int N_TIMERS = 4;

    localparam logic [2:0] SRC_SW  = 3'b000;
    localparam logic [2:0] SRC_T0  = 3'b001;
    localparam logic [2:0] SRC_T2  = 3'b010;
    localparam logic [2:0] SRC_T1  = 3'b011;
    localparam logic [2:0] SRC_EXT = 3'b100;
    localparam logic [2:0] SRC_T3  = 3'b101;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRACK = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic start_int;   // selected internal source fired
        logic start_ext;   // synchronized rising edge on external pin, pin selected
        logic ext_sel;     // external pin is the selected source
        logic ext_lvl;     // synchronized pin level
    } trig_t;

    function automatic logic internal_hit(input logic [2:0] sel,
                                          input logic sw,
                                          input logic [N_TIMERS-1:0] tmr);
        logic hit;
        case (sel)
            SRC_SW:  hit = sw;
            SRC_T0:  hit = tmr[0];
            SRC_T1:  hit = tmr[1];
            SRC_T2:  hit = tmr[2];
            SRC_T3:  hit = tmr[3];
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          trig_sel,
    input  logic                sw_start,
    input  logic [N_TIMERS-1:0] tmr_ovf,
    input  logic                ext_start,
    output trig_t               trig
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_start;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_start};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    always_comb begin
        trig.ext_sel   = (trig_sel == SRC_EXT);
        trig.ext_lvl   = lvl;
        trig.start_ext = trig.ext_sel & lvl & ~prev_q;
        trig.start_int = internal_hit(trig_sel, sw_start, tmr_ovf);
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS      = 10,
    parameter int LP_TRACK_CLKS = 3,
    localparam int STEP_W       = $clog2(RES_BITS + 1),
    localparam int TRK_W        = $clog2(LP_TRACK_CLKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sar_ce,
    input  logic              mode_lp,
    input  logic              sleep,
    input  trig_t             trig,
    output logic              busy,
    output logic              track,
    output logic              conv_active,
    output logic              step_en,
    output logic              last,
    output logic [STEP_W-1:0] step
);

    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(RES_BITS);
    localparam logic [TRK_W-1:0]  TRK_LAST  = TRK_W'(LP_TRACK_CLKS - 1);

    seq_state_e        st_q;
    logic [STEP_W-1:0] step_q;
    logic [TRK_W-1:0]  trk_q;
    logic              track_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            step_q <= '0;
            trk_q  <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    step_q <= '0;
                    trk_q  <= '0;
                    if (!sleep) begin
                        if (trig.start_ext)      st_q <= SEQ_CONV;
                        else if (trig.start_int) st_q <= mode_lp ? SEQ_TRACK : SEQ_CONV;
                    end
                end
                SEQ_TRACK: begin
                    if (sar_ce) begin
                        if (trk_q == TRK_LAST) st_q  <= SEQ_CONV;
                        else                   trk_q <= trk_q + 1'b1;
                    end
                end
                SEQ_CONV: begin
                    if (sar_ce) begin
                        if (step_q == STEP_LAST) st_q   <= SEQ_IDLE;
                        else                     step_q <= step_q + 1'b1;
                    end
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st_q)
            SEQ_IDLE:  track_raw = mode_lp ? (trig.ext_sel & ~trig.ext_lvl) : 1'b1;
            SEQ_TRACK: track_raw = 1'b1;
            default:   track_raw = 1'b0;
        endcase
    end

    assign track       = track_raw & ~sleep;
    assign busy        = (st_q != SEQ_IDLE);
    assign conv_active = (st_q == SEQ_CONV);
    assign step_en     = conv_active & sar_ce;
    assign last        = (step_q == STEP_LAST);
    assign step        = step_q;

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_BITS = 10,
    localparam int STEP_W  = $clog2(RES_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_active,
    input  logic                step_en,
    input  logic                last,
    input  logic [STEP_W-1:0]   step,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                done
);

    localparam logic [RES_BITS-1:0] ONE = RES_BITS'(1);

    logic [RES_BITS-1:0] acc_q;
    logic [RES_BITS-1:0] res_q;
    logic [RES_BITS-1:0] trial;
    logic                done_q;

    always_comb begin
        trial = acc_q;
        if (conv_active && !last)
            trial = acc_q | (ONE << (RES_BITS - 1 - int'(step)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!conv_active) begin
                acc_q <= '0;
            end else if (step_en) begin
                if (last) begin
                    res_q  <= acc_q;
                    done_q <= 1'b1;
                end else if (cmp_in) begin
                    acc_q <= trial;
                end
            end
        end
    end

    assign dac_code = trial;
    assign result   = res_q;
    assign done     = done_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS      = 10,
    parameter int LP_TRACK_CLKS = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sar_ce,
    input  logic                mode_lp,
    input  logic [2:0]          trig_sel,
    input  logic                sw_start,
    input  logic [N_TIMERS-1:0] tmr_ovf,
    input  logic                ext_start,
    input  logic                sleep,
    input  logic                cmp_in,
    output logic                track,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic [RES_BITS-1:0] dac_code
);

    localparam int STEP_W = $clog2(RES_BITS + 1);

    trig_t             trig;
    logic              conv_active;
    logic              step_en;
    logic              last;
    logic [STEP_W-1:0] step;

    adc_trig_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .trig_sel  (trig_sel),
        .sw_start  (sw_start),
        .tmr_ovf   (tmr_ovf),
        .ext_start (ext_start),
        .trig      (trig)
    );

    adc_seq_fsm #(
        .RES_BITS      (RES_BITS),
        .LP_TRACK_CLKS (LP_TRACK_CLKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sar_ce      (sar_ce),
        .mode_lp     (mode_lp),
        .sleep       (sleep),
        .trig        (trig),
        .busy        (busy),
        .track       (track),
        .conv_active (conv_active),
        .step_en     (step_en),
        .last        (last),
        .step        (step)
    );

    adc_sar_core #(
        .RES_BITS (RES_BITS)
    ) u_sar (
        .clk         (clk),
        .rst         (rst),
        .conv_active (conv_active),
        .step_en     (step_en),
        .last        (last),
        .step        (step),
        .cmp_in      (cmp_in),
        .dac_code    (dac_code),
        .result      (result),
        .done        (done)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                sar_ce,
    input logic                mode_lp,
    input logic                sleep,
    input logic                busy,
    input logic                track,
    input logic                done,
    input logic [RES_BITS-1:0] result
);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r6_done_means_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
        (busy && !sar_ce) |=> busy);

    a_r8_sleep_no_track: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !track);

    a_r8_sleep_no_start: assert property (@(posedge clk) disable iff (rst)
        (sleep && !busy) |=> !busy);

    a_r2_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !mode_lp) |-> !track);

    a_r5_result_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sar_ce  (sar_ce),
    .mode_lp (mode_lp),
    .sleep   (sleep),
    .busy    (busy),
    .track   (track),
    .done    (done),
    .result  (result)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int RB  = 10;
    localparam int LPT = 3;
    localparam int CNV = RB + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sar_ce = 1'b0;
    logic          mode_lp = 1'b0;
    logic [2:0]    trig_sel = 3'b000;
    logic          sw_start = 1'b0;
    logic [3:0]    tmr_ovf = 4'b0;
    logic          ext_start = 1'b0;
    logic          sleep = 1'b0;
    logic          cmp_in;
    logic          track, busy, done;
    logic [RB-1:0] result, dac_code;

    int vin = 0;
    int total = 0, bad = 0;
    int ce_div = 1, ce_cnt = 0;
    bit ce_hold = 1'b0;
    int busy_ce = 0, trk_ce = 0, done_cnt = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .sar_ce(sar_ce), .mode_lp(mode_lp),
        .trig_sel(trig_sel), .sw_start(sw_start), .tmr_ovf(tmr_ovf),
        .ext_start(ext_start), .sleep(sleep), .cmp_in(cmp_in),
        .track(track), .busy(busy), .done(done), .result(result),
        .dac_code(dac_code)
    );

    // comparator model: high when the analog input is at or above the trial code
    assign cmp_in = (vin >= int'(dac_code));

    // SAR enable generator, updated just after each rising edge
    always @(posedge clk) begin
        #1;
        if (ce_hold) begin
            sar_ce = 1'b0;
        end else begin
            sar_ce = (ce_cnt == 0);
            ce_cnt = (ce_cnt + 1 >= ce_div) ? 0 : ce_cnt + 1;
        end
    end

    // monitor: values seen here are the ones the next rising edge consumes
    always @(negedge clk) begin
        if (busy && sar_ce)          busy_ce++;
        if (busy && track && sar_ce) trk_ce++;
        if (done)                    done_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_cnt();
        busy_ce = 0; trk_ce = 0; done_cnt = 0;
    endtask

    // src: 0 software, 1..4 timer 0..3, 5 external pin (left high)
    task automatic fire(input int src);
        @(negedge clk);
        if (src == 0)      sw_start = 1'b1;
        else if (src <= 4) tmr_ovf[src-1] = 1'b1;
        else               ext_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        tmr_ovf  = 4'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (done_cnt == 0) check(1'b0, "R6 done never seen", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    function automatic bit exp_start(input int sel, input int src);
        case (src)
            0: return sel == 0;
            1: return sel == 1;
            2: return sel == 3;
            3: return sel == 2;
            4: return sel == 5;
            5: return sel == 4;
            default: return 1'b0;
        endcase
    endfunction

    task automatic conv(input int src, input int sel, input bit mode, input int v);
        int exp_ce, exp_trk;
        @(negedge clk);
        vin = v; trig_sel = 3'(sel); mode_lp = mode;
        clr_cnt();
        fire(src);
        wait_done();
        exp_trk = (mode && src != 5) ? LPT : 0;
        exp_ce  = CNV + exp_trk;
        check(int'(result) == v, "R5 result", int'(result), v);
        if (src == 5)  check(busy_ce == exp_ce, "R4 ext busy cycles", busy_ce, exp_ce);
        else if (mode) check(busy_ce == exp_ce, "R3 lp busy cycles", busy_ce, exp_ce);
        else           check(busy_ce == exp_ce, "R2 busy cycles", busy_ce, exp_ce);
        check(trk_ce == exp_trk, "R3 track window", trk_ce, exp_trk);
        check(done_cnt == 1, "R6 single done", done_cnt, 1);
        if (src == 5) begin
            ext_start = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(done == 1'b0, "R10 done", int'(done), 0);
        check(result == '0, "R10 result", int'(result), 0);
        check(track == 1'b1, "R2 idle track mode0", int'(track), 1);

        // R5 exhaustive, continuous mode, software start
        for (int v = 0; v < (1 << RB); v++) conv(0, 0, 1'b0, v);
        check(track == 1'b1, "R2 idle track after conversion", int'(track), 1);

        // R3 low-power internal starts at a slower enable ratio
        ce_div = 3;
        @(negedge clk);
        mode_lp = 1'b1; trig_sel = 3'b000;
        @(negedge clk);
        check(track == 1'b0, "R3 idle track lp", int'(track), 0);
        for (int v = 0; v < (1 << RB); v += 37) conv(0, 0, 1'b1, v);
        conv(4, 5, 1'b1, (1 << RB) - 1);

        // R4 low-power with external pin
        ce_div = 2;
        @(negedge clk);
        trig_sel = 3'b100; mode_lp = 1'b1; ext_start = 1'b0;
        repeat (3) @(negedge clk);
        check(track == 1'b1, "R4 idle track pin low", int'(track), 1);
        for (int v = 5; v < (1 << RB); v += 97) conv(5, 4, 1'b1, v);
        conv(5, 4, 1'b0, 512);

        // R1 source map sweep, continuous mode
        ce_div = 1;
        for (int sel = 0; sel < 8; sel++) begin
            for (int src = 0; src < 6; src++) begin
                bit e;
                @(negedge clk);
                mode_lp = 1'b0; trig_sel = 3'(sel); vin = 300;
                clr_cnt();
                fire(src);
                if (src == 5) repeat (3) @(negedge clk);
                e = exp_start(sel, src);
                check(busy == e, $sformatf("R1 sel=%0d src=%0d", sel, src), int'(busy), int'(e));
                if (busy) wait_done();
                if (src == 5) begin
                    ext_start = 1'b0;
                    repeat (4) @(negedge clk);
                end
            end
        end

        // R7 starts while busy are ignored
        ce_div = 2;
        @(negedge clk);
        trig_sel = 3'b000; mode_lp = 1'b0; vin = 777;
        clr_cnt();
        fire(0);
        repeat (4) @(negedge clk);
        fire(0);
        repeat (3) @(negedge clk);
        fire(0);
        wait_done();
        repeat (40) @(negedge clk);
        check(done_cnt == 1, "R7 one done", done_cnt, 1);
        check(busy_ce == CNV, "R7 length unchanged", busy_ce, CNV);
        check(busy == 1'b0, "R7 idle afterwards", int'(busy), 0);
        check(int'(result) == 777, "R7 result", int'(result), 777);

        // R9 no progress without enable
        ce_div = 1;
        @(negedge clk);
        ce_hold = 1'b1; vin = 123;
        clr_cnt();
        fire(0);
        repeat (40) @(negedge clk);
        check(busy == 1'b1, "R9 still busy", int'(busy), 1);
        check(done_cnt == 0, "R9 no done", done_cnt, 0);
        ce_hold = 1'b0;
        wait_done();
        check(busy_ce == CNV, "R9 length after release", busy_ce, CNV);
        check(int'(result) == 123, "R9 result", int'(result), 123);

        // R8 sleep
        @(negedge clk);
        sleep = 1'b1; mode_lp = 1'b0; trig_sel = 3'b000;
        clr_cnt();
        @(negedge clk);
        check(track == 1'b0, "R8 track off", int'(track), 0);
        fire(0);
        repeat (20) @(negedge clk);
        check(busy == 1'b0, "R8 no start", int'(busy), 0);
        check(done_cnt == 0, "R8 no done", done_cnt, 0);
        check(int'(result) == 123, "R8 result kept", int'(result), 123);
        sleep = 1'b0;
        @(negedge clk);
        check(track == 1'b1, "R8 track back", int'(track), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule